// File: doc/BRIEF.md
# Misaligned Eight-Byte Read Combiner

This block serves 8-byte reads that may start at any byte address, sitting in front of a word-wide store made of eight byte-wide banks that are all read in the same cycle. Byte address bits [2:0] pick the bank and the upper bits pick the row shared by every bank. A single word access therefore yields eight consecutive bytes, but only when they start on an 8-byte boundary.

A request whose start byte is on a boundary is served with one word access. Any other request triggers two word accesses in consecutive cycles: first the word holding the start byte, then the word after it, with the row index wrapping at the top of the store. The wanted bytes are then taken from the concatenation of the two words, in little-endian order. One request is in flight at a time. The response is a one-cycle pulse together with a flag saying whether the request needed two accesses.

Top module: `split_read_merger`

## Requirements
- R1: A request with addr[2:0] == 0 drives exactly one cycle of mem_rd_en, and rsp_valid rises in the third cycle after the accepting cycle.
- R2: The first word access after acceptance uses mem_rd_addr == req_addr[ADDR_W-1:3].
- R3: A request with addr[2:0] != 0 drives mem_rd_en for exactly two consecutive cycles, and the second mem_rd_addr is the first plus one, modulo 2^(ADDR_W-3).
- R4: Byte i of rsp_data (bits 8i+7:8i) equals the stored byte at byte address (req_addr + i) modulo 2^ADDR_W, for i = 0..7.
- R5: A request with addr[2:0] != 0 takes one cycle more than an aligned one: rsp_valid rises in the fourth cycle after acceptance.
- R6: req_ready is high only when no request is in flight. A req_valid presented while busy is ignored and produces no response and no memory access.
- R7: rsp_valid is high for exactly one cycle per accepted request.
- R8: rsp_split is 1 after a request with addr[2:0] != 0 and 0 after an aligned one, and holds that value until the next response.
- R9: Synchronous active-high reset, including one applied in the middle of a request, leaves req_ready = 1, rsp_valid = 0, mem_rd_en = 0 and rsp_split = 0, with no late response afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | ADDR_W | Start byte address |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | 8*BYTE_W | Eight bytes, lowest address in the low byte |
| rsp_split | output | 1 | Last request needed two word accesses |
| mem_rd_en | output | 1 | Word read strobe to the bank array |
| mem_rd_addr | output | ADDR_W-3 | Row index for all banks |
| mem_rd_data | input | 8*BYTE_W | Bank array read word, one cycle after the strobe |

## Verification
The assertions assume the bank array returns the word for a strobed row exactly one cycle after the strobe, and that reset is held for at least one clock edge before the first request. The bench model is a synchronous array with that fixed latency. Its contents are a computed function of the byte address, so every byte position and both words are distinct. The bench applies reset at the start and once mid-request, then sweeps every start address, including ones whose second word wraps past the top row. While busy, it presents extra requests only through req_valid and drops them before the idle cycle, so the one-in-flight rule is exercised without breaking the fixed-latency assumption.

// File: rtl/srm_pkg.sv
package srm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ISSUE  = 2'd1,
    ST_SECOND = 2'd2,
    ST_LAST   = 2'd3
  } srm_state_e;
endpackage

// File: rtl/srm_merge.sv
module srm_merge #(
  parameter int BANKS  = 8,
  parameter int BYTE_W = 8
) (
  input  logic [BANKS*BYTE_W-1:0]   lo_word,
  input  logic [BANKS*BYTE_W-1:0]   hi_word,
  input  logic [$clog2(BANKS)-1:0]  ofs,
  output logic [BANKS*BYTE_W-1:0]   merged
);
  localparam int WORD_W = BANKS * BYTE_W;

  logic [2*WORD_W-1:0] pair;
  logic [WORD_W-1:0]   cand [BANKS];

  assign pair = {hi_word, lo_word};

  // one candidate window per byte offset
  for (genvar k = 0; k < BANKS; k++) begin : g_win
    assign cand[k] = pair[k*BYTE_W +: WORD_W];
  end

  assign merged = cand[ofs];

  // R4: the low byte of the result is the start byte inside the first word
  always_comb begin
    a_r4_low_byte: assert (merged[BYTE_W-1:0] == lo_word[ofs*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/srm_ctrl.sv
module srm_ctrl
  import srm_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANKS  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [ADDR_W-1:0]                 req_addr,
  output logic                              mem_rd_en,
  output logic [ADDR_W-$clog2(BANKS)-1:0]   mem_rd_addr,
  input  logic [BANKS*BYTE_W-1:0]           mem_rd_data,
  output logic [BANKS*BYTE_W-1:0]           mrg_lo,
  output logic [BANKS*BYTE_W-1:0]           mrg_hi,
  output logic [$clog2(BANKS)-1:0]          mrg_ofs,
  input  logic [BANKS*BYTE_W-1:0]           mrg_word,
  output logic                              rsp_valid,
  output logic [BANKS*BYTE_W-1:0]           rsp_data,
  output logic                              rsp_split
);
  localparam int WORD_W = BANKS * BYTE_W;
  localparam int OFS_W  = $clog2(BANKS);
  localparam int WA_W   = ADDR_W - OFS_W;
  localparam logic [WA_W-1:0]  WA_ONE   = WA_W'(1);
  localparam logic [OFS_W-1:0] OFS_ZERO = '0;

  srm_state_e        state;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] word0_q;
  logic              split;
  logic              accept;

  assign split     = (ofs_q != OFS_ZERO);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;

  assign mrg_lo  = split ? word0_q : mem_rd_data;
  assign mrg_hi  = mem_rd_data;
  assign mrg_ofs = ofs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      ofs_q       <= '0;
      word0_q     <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
      rsp_valid   <= 1'b0;
      rsp_data    <= '0;
      rsp_split   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            ofs_q       <= req_addr[OFS_W-1:0];
            mem_rd_addr <= req_addr[ADDR_W-1:OFS_W];
            mem_rd_en   <= 1'b1;
            state       <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (split) begin
            mem_rd_addr <= mem_rd_addr + WA_ONE;
            state       <= ST_SECOND;
          end else begin
            mem_rd_en <= 1'b0;
            state     <= ST_LAST;
          end
        end
        ST_SECOND: begin
          word0_q   <= mem_rd_data;
          mem_rd_en <= 1'b0;
          state     <= ST_LAST;
        end
        ST_LAST: begin
          rsp_valid <= 1'b1;
          rsp_data  <= mrg_word;
          rsp_split <= split;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: first access targets the row of the start byte
  a_r2_first_row: assert property (@(posedge clk) disable iff (rst)
    accept |=> (mem_rd_en && mem_rd_addr == $past(req_addr[ADDR_W-1:OFS_W])));

  // R1: aligned request, single access, response two cycles after it
  a_r1_aligned_single: assert property (@(posedge clk) disable iff (rst)
    (accept && req_addr[OFS_W-1:0] == OFS_ZERO)
      |=> mem_rd_en ##1 !mem_rd_en ##1 rsp_valid);

  // R3 and R5: misaligned request, two back-to-back accesses, one cycle later
  a_r3_two_access: assert property (@(posedge clk) disable iff (rst)
    (accept && req_addr[OFS_W-1:0] != OFS_ZERO)
      |=> mem_rd_en ##1 mem_rd_en ##1 !mem_rd_en ##1 rsp_valid);

  // R3: second row is the next one, wrapping at the top
  a_r3_next_row: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_en && $past(mem_rd_en)) |-> (mem_rd_addr == $past(mem_rd_addr) + WA_ONE));

  // R7: response strobe lasts one cycle
  a_r7_rsp_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R6: a response always follows a busy cycle
  a_r6_busy_before_rsp: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(!req_ready));

  // R9: reset clears outputs
  a_r9_reset_clears: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !mem_rd_en && req_ready && !rsp_split));
endmodule

// File: rtl/split_read_merger.sv
module split_read_merger #(
  parameter int ADDR_W = 12,
  parameter int BANKS  = 8,
  parameter int BYTE_W = 8
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             req_valid,
  output logic                             req_ready,
  input  logic [ADDR_W-1:0]                req_addr,
  output logic                             rsp_valid,
  output logic [BANKS*BYTE_W-1:0]          rsp_data,
  output logic                             rsp_split,
  output logic                             mem_rd_en,
  output logic [ADDR_W-$clog2(BANKS)-1:0]  mem_rd_addr,
  input  logic [BANKS*BYTE_W-1:0]          mem_rd_data
);
  localparam int WORD_W = BANKS * BYTE_W;
  localparam int OFS_W  = $clog2(BANKS);

  logic [WORD_W-1:0] lo_w;
  logic [WORD_W-1:0] hi_w;
  logic [WORD_W-1:0] merged_w;
  logic [OFS_W-1:0]  ofs_w;

  srm_ctrl #(
    .ADDR_W (ADDR_W),
    .BANKS  (BANKS),
    .BYTE_W (BYTE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_data (mem_rd_data),
    .mrg_lo      (lo_w),
    .mrg_hi      (hi_w),
    .mrg_ofs     (ofs_w),
    .mrg_word    (merged_w),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_split   (rsp_split)
  );

  srm_merge #(
    .BANKS  (BANKS),
    .BYTE_W (BYTE_W)
  ) u_merge (
    .lo_word (lo_w),
    .hi_word (hi_w),
    .ofs     (ofs_w),
    .merged  (merged_w)
  );
endmodule

// File: tb/split_read_merger_bench.sv
`timescale 1ns/1ps
module split_read_merger_bench;
  localparam int ADDR_W = 12;
  localparam int BANKS  = 8;
  localparam int BYTE_W = 8;
  localparam int WORD_W = BANKS * BYTE_W;
  localparam int OFS_W  = 3;
  localparam int WA_W   = ADDR_W - OFS_W;
  localparam int DEPTH  = 1 << WA_W;
  localparam int NBYTES = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic              rsp_valid;
  logic [WORD_W-1:0] rsp_data;
  logic              rsp_split;
  logic              mem_rd_en;
  logic [WA_W-1:0]   mem_rd_addr;
  logic [WORD_W-1:0] mem_rd_data = '0;
  logic [WORD_W-1:0] ram [DEPTH];

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  split_read_merger #(.ADDR_W(ADDR_W), .BANKS(BANKS), .BYTE_W(BYTE_W)) u_split_read_merger (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_split(rsp_split), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data)
  );

  // bank array: fixed one-cycle read latency
  always_ff @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= ram[mem_rd_addr];
  end

  function automatic logic [7:0] byte_at(input int a);
    return 8'(((a * 37) + ((a >> 5) * 11) + 5) ^ (a >> 7));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_req(input int a, input bit junk);
    int cyc = 0;
    int en  = 0;
    int r0  = 0;
    int r1  = 0;
    bit busy_ok = 1'b1;
    bit split_exp;
    logic [WORD_W-1:0] exp_d;
    logic [WORD_W-1:0] got;
    logic got_split;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = ADDR_W'(a);
    @(posedge clk);
    do begin
      @(negedge clk);
      cyc++;
      if (mem_rd_en) begin
        en++;
        if (en == 1) r0 = int'(mem_rd_addr);
        if (en == 2) r1 = int'(mem_rd_addr);
      end
      if (!rsp_valid && req_ready) busy_ok = 1'b0;
      if (junk && !rsp_valid) begin
        req_valid = 1'b1;
        req_addr  = ADDR_W'(a ^ 12'h5a5);
      end else begin
        req_valid = 1'b0;
      end
    end while (!rsp_valid && cyc < 10);
    req_valid = 1'b0;
    got = rsp_data;
    got_split = rsp_split;
    split_exp = (a % 8) != 0;
    for (int i = 0; i < BANKS; i++) exp_d[i*8 +: 8] = byte_at((a + i) % NBYTES);
    // R1 / R5 latency
    chk(cyc == (split_exp ? 4 : 3), split_exp ? "R5 latency" : "R1 latency", 64'(cyc), split_exp ? 64'd4 : 64'd3);
    // R1 / R3 access count
    chk(en == (split_exp ? 2 : 1), split_exp ? "R3 access count" : "R1 access count", 64'(en), split_exp ? 64'd2 : 64'd1);
    chk(r0 == a / 8, "R2 first row", 64'(r0), 64'(a / 8));
    if (split_exp) chk(r1 == (a / 8 + 1) % DEPTH, "R3 second row", 64'(r1), 64'((a / 8 + 1) % DEPTH));
    chk(got == exp_d, "R4 data", got, exp_d);
    chk(got_split == split_exp, "R8 split flag", 64'(got_split), 64'(split_exp));
    chk(busy_ok, "R6 ready low while busy", 64'(busy_ok), 64'd1);
    @(negedge clk);
    chk(!rsp_valid, "R7 single-cycle pulse", 64'(rsp_valid), 64'd0);
    chk(rsp_split == split_exp, "R8 flag held", 64'(rsp_split), 64'(split_exp));
    if (junk) begin
      int extra = 0;
      for (int k = 0; k < 4; k++) begin
        if (rsp_valid || mem_rd_en || !req_ready) extra++;
        @(negedge clk);
      end
      chk(extra == 0, "R6 busy request ignored", 64'(extra), 64'd0);
    end
  endtask

  // watchdog
  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        n_fail++;
        n_run++;
        $display("FAIL watchdog actual=%0d expected<100000", cycles);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    for (int w = 0; w < DEPTH; w++)
      for (int b = 0; b < BANKS; b++)
        ram[w][b*8 +: 8] = byte_at(w * 8 + b);
    req_valid = 1'b1;
    req_addr  = 12'h003;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready, "R9 reset ready", 64'(req_ready), 64'd1);
    chk(!rsp_valid, "R9 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk(!mem_rd_en, "R9 reset mem_rd_en", 64'(mem_rd_en), 64'd0);
    chk(!rsp_split, "R9 reset rsp_split", 64'(rsp_split), 64'd0);
    req_valid = 1'b0;
    rst = 1'b0;

    // full sweep of start addresses, covering wrap at the top row (R3, R4)
    for (int a = 0; a < NBYTES; a++) run_req(a, 1'b0);

    // busy requests ignored (R6)
    for (int a = 0; a < 16; a++) run_req(a, 1'b1);
    run_req(NBYTES - 3, 1'b1);

    // mid-request reset (R9)
    begin
      int late = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = 12'h2f5;
      @(negedge clk);
      req_valid = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(req_ready && !mem_rd_en && !rsp_valid && !rsp_split, "R9 mid-request reset",
          {60'd0, req_ready, mem_rd_en, rsp_valid, rsp_split}, 64'h8);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (rsp_valid || mem_rd_en) late++;
      end
      chk(late == 0, "R9 no late response", 64'(late), 64'd0);
    end
    run_req(12'h2f5, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule